// File: doc/BRIEF.md
# ADC Power-Up Sequencer with Output Muting

This block runs the digital side of an audio converter's start-up. It watches an active-low power-down pin and a clock-presence flag. While either one calls for power-down, the block keeps all stages off, holds the downstream filter in reset and drives zero on both sample channels.

Once power-down is released, the block switches on the charge-pump stage first. It then counts frame-clock strobes. After a mode-dependent number of frames it enables the pre-amplifier. After a second, longer count it declares the data valid and stops muting the 24-bit sample path.

Two timing modes are supported, slave and master, and they use slightly different counts. The mode is taken only while the block sits in power-down. Any request for power-down, whether from the pin or from missing clocks, drops the block straight back to its idle state and clears the frame count.

Top module: `adc_pwrup_seq`

## Requirements
- R1: While power-down is in effect, `filt_rst` is 1, and `cp_en`, `preamp_en` and `data_valid` are 0. Both sample outputs are 0. The `pdn_n` pin passes through two synchronizer flops, so a change on it reaches the outputs within three clock cycles.
- R2: In slave mode (`master_mode` = 0), `cp_en` rises when power-down is released. `preamp_en` rises on the clock after the 260th frame strobe counted from that release, and not earlier.
- R3: In master mode (`master_mode` = 1), `preamp_en` rises on the clock after the 257th frame strobe counted from release, and not earlier.
- R4: `data_valid` rises on the clock after the 4388th frame strobe in slave mode, or after the 4385th in master mode, counted from release.
- R5: The stages come up in a fixed order. `preamp_en` is never 1 without `cp_en`, and `data_valid` is never 1 without `preamp_en`.
- R6: While `data_valid` is 0, both sample outputs are two's-complement zero. While `data_valid` is 1, each output equals its input sample in the same cycle.
- R7: A 0 on `clocks_ok` puts the block into power-down on the next clock edge, from any state.
- R8: Power-down requested in any state clears the frame count. Frame strobes that arrive during power-down are not counted, and the next release runs the full count again.
- R9: `master_mode` is sampled only while in power-down. A change of `master_mode` after release has no effect on the counts until the next power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Power-down pin, active low, asynchronous |
| master_mode | input | 1 | Timing mode select: 0 = slave, 1 = master |
| frame_tick | input | 1 | Single-cycle frame-clock strobe in the `clk` domain |
| clocks_ok | input | 1 | 1 while all converter clocks are present |
| smp_in_l | input | 24 | Left-channel sample from the converter |
| smp_in_r | input | 24 | Right-channel sample from the converter |
| cp_en | output | 1 | Charge-pump stage enable |
| preamp_en | output | 1 | Pre-amplifier enable |
| filt_rst | output | 1 | Reset for the downstream filter |
| data_valid | output | 1 | Sample outputs carry live data |
| smp_out_l | output | 24 | Left-channel sample, forced to zero until valid |
| smp_out_r | output | 24 | Right-channel sample, forced to zero until valid |

## Verification
The assertions assume that `frame_tick` is already a one-cycle pulse in the `clk` domain and that `clocks_ok` is synchronous to `clk`. They also assume that strobes arrive far apart compared with the three-cycle latency of the power-down path. The stimulus drives every input on the falling edge and spaces frame strobes four clocks apart. After each change to `pdn_n` it waits four clocks before sending strobes, so every count begins from a settled release. The mode-change and abort scenarios alter inputs only between strobes, never in the same cycle as one.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the ADC power-up sequencer.
package adc_seq_pkg;
    // Sequencer phases, in the order they are entered after release.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PUMP = 2'd1,
        ST_INIT = 2'd2,
        ST_LIVE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pd_sync.sv
// pd_sync: multi-flop synchronizer for the asynchronous power-down pin.
// Assumes: the pin is slow compared with clk. Reset forces the
// synchronized value to 0, which means power-down.
module pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_n_s
);
    logic [STAGES-1:0] sync_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_n};
    end

    assign pin_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/seq_fsm.sv
// seq_fsm: phase state machine plus the frame counter.
// Assumes: frame_tick is a one-cycle strobe in the clk domain, and
// pd_req is already synchronous. The mode is latched only in ST_OFF.
module seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SLV_CP   = 260,
    parameter int MST_CP   = 257,
    parameter int SLV_INIT = 4388,
    parameter int MST_INIT = 4385
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       master_mode,
    input  logic       frame_tick,
    output seq_state_t state,
    output logic       mode_q
);
    localparam int MAXLEN = (SLV_INIT > MST_INIT) ? SLV_INIT : MST_INIT;
    localparam int CNT_W  = $clog2(MAXLEN + 1);
    localparam logic [CNT_W-1:0] SLV_CP_C   = CNT_W'(SLV_CP);
    localparam logic [CNT_W-1:0] MST_CP_C   = CNT_W'(MST_CP);
    localparam logic [CNT_W-1:0] SLV_INIT_C = CNT_W'(SLV_INIT);
    localparam logic [CNT_W-1:0] MST_INIT_C = CNT_W'(MST_INIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] pump_len;
    logic [CNT_W-1:0] init_len;

    // Pick the two counts for the latched mode.
    always_comb begin
        pump_len = mode_q ? MST_CP_C   : SLV_CP_C;
        init_len = mode_q ? MST_INIT_C : SLV_INIT_C;
        cnt_nx   = cnt_q + 1'b1;
    end

    // Latch the mode while idle; it holds once the sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_q <= 1'b0;
        else if (state == ST_OFF) mode_q <= master_mode;
    end

    // Phase transitions and frame counting.
    always_ff @(posedge clk) begin
        if (!rst_n || pd_req) begin
            state <= ST_OFF;
            cnt_q <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    state <= ST_PUMP;
                    cnt_q <= '0;
                end
                ST_PUMP: if (frame_tick) begin
                    cnt_q <= cnt_nx;
                    if (cnt_nx == pump_len) state <= ST_INIT;
                end
                ST_INIT: if (frame_tick) begin
                    cnt_q <= cnt_nx;
                    if (cnt_nx == init_len) state <= ST_LIVE;
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/zero_mux.sv
// zero_mux: forces every channel of the sample path to zero unless
// pass is 1. Purely combinational, so there is no added latency.
module zero_mux #(
    parameter int W  = 24,
    parameter int CH = 2
) (
    input  logic                 pass,
    input  logic [CH-1:0][W-1:0] din,
    output logic [CH-1:0][W-1:0] dout
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        // Gate one channel.
        assign dout[c] = pass ? din[c] : '0;
    end
endmodule

// File: rtl/adc_pwrup_seq.sv
// adc_pwrup_seq: top of the power-up sequencer. It combines the pin
// synchronizer, the phase machine and the output mute. Assumes:
// frame_tick and clocks_ok are synchronous to clk.
module adc_pwrup_seq
    import adc_seq_pkg::*;
#(
    parameter int W        = 24,
    parameter int SYNC_N   = 2,
    parameter int SLV_CP   = 260,
    parameter int MST_CP   = 257,
    parameter int SLV_INIT = 4388,
    parameter int MST_INIT = 4385
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pdn_n,
    input  logic         master_mode,
    input  logic         frame_tick,
    input  logic         clocks_ok,
    input  logic [W-1:0] smp_in_l,
    input  logic [W-1:0] smp_in_r,
    output logic         cp_en,
    output logic         preamp_en,
    output logic         filt_rst,
    output logic         data_valid,
    output logic [W-1:0] smp_out_l,
    output logic [W-1:0] smp_out_r
);
    logic            pdn_n_s;
    logic            pd_req;
    logic            mode_q;
    seq_state_t      state;
    logic [1:0][W-1:0] mux_out;

    pd_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(pdn_n), .pin_n_s(pdn_n_s)
    );

    // Power-down is requested by the pin or by missing clocks.
    assign pd_req = !pdn_n_s || !clocks_ok;

    seq_fsm #(
        .SLV_CP(SLV_CP), .MST_CP(MST_CP),
        .SLV_INIT(SLV_INIT), .MST_INIT(MST_INIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req),
        .master_mode(master_mode), .frame_tick(frame_tick),
        .state(state), .mode_q(mode_q)
    );

    // Decode the stage enables from the phase.
    always_comb begin
        filt_rst   = (state == ST_OFF);
        cp_en      = (state != ST_OFF);
        preamp_en  = (state == ST_INIT) || (state == ST_LIVE);
        data_valid = (state == ST_LIVE);
    end

    zero_mux #(.W(W), .CH(2)) u_mute (
        .pass(data_valid), .din({smp_in_r, smp_in_l}), .dout(mux_out)
    );

    assign smp_out_l = mux_out[0];
    assign smp_out_r = mux_out[1];
endmodule

// File: rtl/adc_pwrup_seq_chk.sv
// adc_pwrup_seq_chk: assertion checker bound to adc_pwrup_seq. It keeps
// its own frame count from the rise of cp_en and uses it to check the
// stage timing.
module adc_pwrup_seq_chk #(
    parameter int W        = 24,
    parameter int SLV_CP   = 260,
    parameter int MST_CP   = 257,
    parameter int SLV_INIT = 4388,
    parameter int MST_INIT = 4385
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_tick,
    input logic         pd_req,
    input logic         mode_q,
    input logic         cp_en,
    input logic         preamp_en,
    input logic         filt_rst,
    input logic         data_valid,
    input logic [W-1:0] smp_in_l,
    input logic [W-1:0] smp_in_r,
    input logic [W-1:0] smp_out_l,
    input logic [W-1:0] smp_out_r
);
    logic [15:0] ref_cnt;

    // Count frame strobes since the charge pump came on.
    always_ff @(posedge clk) begin
        if (!rst_n || !cp_en)                    ref_cnt <= '0;
        else if (frame_tick && ref_cnt != 16'hFFFF) ref_cnt <= ref_cnt + 1'b1;
    end

    a_r1_pd_state: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> (filt_rst && !cp_en && !preamp_en && !data_valid));
    a_r2_r3_preamp_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preamp_en) |-> (ref_cnt == (mode_q ? 16'(MST_CP) : 16'(SLV_CP))));
    a_r4_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> (ref_cnt == (mode_q ? 16'(MST_INIT) : 16'(SLV_INIT))));
    a_r5_preamp_order: assert property (@(posedge clk) disable iff (!rst_n)
        preamp_en |-> cp_en);
    a_r5_valid_order: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> preamp_en);
    a_r6_muted: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (smp_out_l == '0 && smp_out_r == '0));
    a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (smp_out_l == smp_in_l && smp_out_r == smp_in_r));
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |=> $stable(mode_q));
endmodule

bind adc_pwrup_seq adc_pwrup_seq_chk #(
    .W(W), .SLV_CP(SLV_CP), .MST_CP(MST_CP),
    .SLV_INIT(SLV_INIT), .MST_INIT(MST_INIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pd_req(pd_req),
    .mode_q(mode_q), .cp_en(cp_en), .preamp_en(preamp_en),
    .filt_rst(filt_rst), .data_valid(data_valid),
    .smp_in_l(smp_in_l), .smp_in_r(smp_in_r),
    .smp_out_l(smp_out_l), .smp_out_r(smp_out_r)
);

// File: tb/adc_pwrup_seq_bench.sv
// adc_pwrup_seq_bench: directed bench. Each scenario is a task that
// checks its own results.
module adc_pwrup_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pdn_n = 1'b0;
    logic        master_mode = 1'b0;
    logic        frame_tick = 1'b0;
    logic        clocks_ok = 1'b1;
    logic [23:0] smp_in_l = 24'h5A5A5A;
    logic [23:0] smp_in_r = 24'hA00001;
    logic        cp_en, preamp_en, filt_rst, data_valid;
    logic [23:0] smp_out_l, smp_out_r;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    adc_pwrup_seq u_adc_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .master_mode(master_mode),
        .frame_tick(frame_tick), .clocks_ok(clocks_ok),
        .smp_in_l(smp_in_l), .smp_in_r(smp_in_r),
        .cp_en(cp_en), .preamp_en(preamp_en), .filt_rst(filt_rst),
        .data_valid(data_valid), .smp_out_l(smp_out_l), .smp_out_r(smp_out_r)
    );

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles expected < 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            frame_tick = 1'b1;
            @(negedge clk);
            frame_tick = 1'b0;
            wait_clks(3);
        end
    endtask

    task automatic check_off(input string req);
        check({req, " filt_rst"}, filt_rst, 1);
        check({req, " cp_en"}, cp_en, 0);
        check({req, " preamp_en"}, preamp_en, 0);
        check({req, " data_valid"}, data_valid, 0);
        check({req, " out zero"}, {smp_out_l, smp_out_r}, 0);
    endtask

    task automatic release_pd();
        pdn_n = 1'b1;
        wait_clks(4);
    endtask

    task automatic enter_pd();
        pdn_n = 1'b0;
        wait_clks(4);
    endtask

    task automatic t_reset();
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(3);
        check_off("R1 reset");
    endtask

    task automatic t_sequence(input logic mode, input int cp, input int ini, input string rq);
        master_mode = mode;
        wait_clks(2);
        release_pd();
        check("R2 cp_en after release", cp_en, 1);
        check("R1 filt_rst released", filt_rst, 0);
        ticks(cp - 1);
        check({rq, " preamp early"}, preamp_en, 0);
        ticks(1);
        check({rq, " preamp on"}, preamp_en, 1);
        check("R6 mute during init", {data_valid, smp_out_l, smp_out_r}, 0);
        ticks(ini - cp - 1);
        check("R4 valid early", data_valid, 0);
        ticks(1);
        check("R4 valid on", data_valid, 1);
        check("R5 stages on", {cp_en, preamp_en}, 2'b11);
        check("R6 pass left", smp_out_l, smp_in_l);
        check("R6 pass right", smp_out_r, smp_in_r);
        smp_in_l = 24'h800000;
        #1;
        check("R6 pass same cycle", smp_out_l, 24'h800000);
        enter_pd();
        check_off("R1 pdn low");
    endtask

    task automatic t_mode_ignored();
        master_mode = 1'b0;
        wait_clks(2);
        release_pd();
        master_mode = 1'b1;
        ticks(257);
        check("R9 mode change ignored", preamp_en, 0);
        ticks(3);
        check("R9 slave count kept", preamp_en, 1);
        enter_pd();
        master_mode = 1'b0;
    endtask

    task automatic t_abort();
        release_pd();
        ticks(200);
        enter_pd();
        check_off("R8 abort");
        ticks(50);
        check("R8 ticks in power-down", cp_en, 0);
        release_pd();
        ticks(259);
        check("R8 count restarted", preamp_en, 0);
        ticks(1);
        check("R8 full count", preamp_en, 1);
        enter_pd();
    endtask

    task automatic t_clock_loss();
        release_pd();
        ticks(4388);
        check("R7 running", data_valid, 1);
        clocks_ok = 1'b0;
        wait_clks(1);
        check_off("R7 clocks lost");
        clocks_ok = 1'b1;
        wait_clks(2);
        check("R7 restart", {cp_en, preamp_en}, 2'b10);
        enter_pd();
    endtask

    initial begin
        t_reset();
        t_sequence(1'b0, 260, 4388, "R2");
        t_sequence(1'b1, 257, 4385, "R3");
        t_mode_ignored();
        t_abort();
        t_clock_loss();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule